// File: doc/BRIEF.md
# Windowed Message FIFO Pair

This block holds the host-side message buffering for a bus controller: one receive queue and one transmit queue, each four message entries deep. A message entry is a 32-bit identifier word, a 4-bit length code and 64 bits of payload. The host does not push or pop the queues directly. It looks at each queue through a fixed register window. The receive window always shows the oldest unread entry. The transmit window is a staging area that the host fills field by field.

The window contents move only when the host writes the key value 0xFF to a queue's pointer register. On the receive side this retires the displayed entry and brings the next one into view. On the transmit side it commits the staged message into the queue. The bus side fills the receive queue through a message-input port and is offered the oldest transmit entry on a message-output port, which it retires with a done pulse. Both queues raise interrupt status bits. The transmit interrupt can be set to fire either on every completion or only when a completion leaves the queue empty.

The identifier word is stored and returned unchanged. Its layout (extended flag at bit 31, remote flag at bit 30, a standard identifier at bits 28:18 or an extended one at bits 28:0) is the bus side's concern. Register addresses used below are on the 4-bit `host_addr`: 0 to 3 are the receive window (identifier, length code in bits 3:0, payload bytes 0-3, payload bytes 4-7), 4 to 7 are the transmit staging window in the same order, 8 is receive control, 9 is transmit control, 10 is the receive pointer, 11 is the transmit pointer, 12 is interrupt enable and 13 is interrupt status.

Top module: `mbx_fifo_pair`

## Requirements
- R1: After reset both queues are empty and disabled, receive control reads 0x80, transmit control reads 0x00, `tx_valid` is low and both interrupt outputs are low.
- R2: In both control registers bit 0 is the queue enable (writable) and bits 3:1 give the number of stored entries (unread for receive, unsent for transmit). In receive control, bit 7 reads 1 exactly when no unread entry remains. All other control bits read 0, and writes to them have no effect.
- R3: A `rx_valid` cycle stores the message when receive is enabled and fewer than four entries are held. A message presented while receive is disabled is discarded. Entries leave in arrival order, and addresses 0 to 3 show the oldest unread entry with its length code in bits 3:0 of address 1.
- R4: Writing 0xFF to the receive pointer (address 10) retires the displayed entry. Any other value, a write while receive is disabled and a write while the queue is empty all leave the queue unchanged.
- R5: A message presented while receive is enabled and four entries are held is discarded. `rx_overrun` is high in that same cycle, and the stored entries are not altered.
- R6: Writing 0xFF to the transmit pointer (address 11) appends the staged fields (addresses 4 to 7) to the transmit queue. Any other value, a write while transmit is disabled and a write while four entries are held are ignored.
- R7: `tx_valid` is high while transmit is enabled and at least one entry is held. `tx_id`, `tx_dlc` and `tx_data` then carry the oldest entry, and a `tx_done` pulse while `tx_valid` is high retires it.
- R8: With interrupt enable bit 1 set, a retired transmit entry sets status bit 1. If enable bit 2 is also set, only a retirement that leaves the transmit queue empty sets it.
- R9: With interrupt enable bit 0 set, each stored receive message sets status bit 0. `irq_rx` and `irq_tx` show status bits 0 and 1, and writing 1 to a status bit (address 13) clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` (combinational) |
| rx_valid | input | 1 | Incoming message present this cycle |
| rx_id | input | 32 | Incoming identifier word |
| rx_dlc | input | 4 | Incoming length code |
| rx_data | input | 64 | Incoming payload, byte 0 in bits 7:0 |
| rx_overrun | output | 1 | Incoming message dropped because the queue is full |
| tx_valid | output | 1 | Oldest transmit entry offered |
| tx_id | output | 32 | Offered identifier word |
| tx_dlc | output | 4 | Offered length code |
| tx_data | output | 64 | Offered payload |
| tx_done | input | 1 | Bus side finished the offered entry |
| irq_rx | output | 1 | Receive interrupt status |
| irq_tx | output | 1 | Transmit interrupt status |

## Verification
Register reads are combinational. A result that follows a register write, a `rx_valid` cycle or a `tx_done` pulse becomes visible one clock edge later. This applies to window contents, counts, flags, `tx_valid` and the interrupt outputs. `rx_overrun` is judged in the same cycle the message is presented. The bench drives every stimulus on the falling edge. It samples `rx_overrun` just before the next rising edge and samples every other result on the falling edge after that rising edge, comparing each against a queue model kept in the bench.

// File: rtl/mbxq_pkg.sv
package mbxq_pkg;

  typedef struct packed {
    logic [31:0] id;
    logic [3:0]  dlc;
    logic [63:0] data;
  } frame_t;

  localparam logic [7:0] PTR_KEY = 8'hFF;

  localparam logic [3:0] A_RX_ID   = 4'd0;
  localparam logic [3:0] A_RX_DLC  = 4'd1;
  localparam logic [3:0] A_RX_DLO  = 4'd2;
  localparam logic [3:0] A_RX_DHI  = 4'd3;
  localparam logic [3:0] A_TX_ID   = 4'd4;
  localparam logic [3:0] A_TX_DLC  = 4'd5;
  localparam logic [3:0] A_TX_DLO  = 4'd6;
  localparam logic [3:0] A_TX_DHI  = 4'd7;
  localparam logic [3:0] A_RX_CTL  = 4'd8;
  localparam logic [3:0] A_TX_CTL  = 4'd9;
  localparam logic [3:0] A_RX_PTR  = 4'd10;
  localparam logic [3:0] A_TX_PTR  = 4'd11;
  localparam logic [3:0] A_IRQ_EN  = 4'd12;
  localparam logic [3:0] A_IRQ_ST  = 4'd13;

  // control byte: [7] empty flag, [3:1] entry count, [0] enable
  function automatic logic [7:0] ctrl_byte(input logic en, input logic [2:0] cnt,
                                           input logic empty_flag);
    return {empty_flag, 3'b000, cnt, en};
  endfunction

  function automatic logic is_key(input logic [31:0] wdata);
    return wdata[7:0] == PTR_KEY;
  endfunction

endpackage

// File: rtl/msgq_ring.sv
module msgq_ring
  import mbxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  frame_t        push_frame,
  input  logic          pop,
  output frame_t        head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  frame_t        mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_frame;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> count == CW'($past(count) + 1'b1));

endmodule

// File: rtl/msgq_irq.sv
module msgq_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_accept,
  input  logic       tx_retire,
  input  logic       tx_drained,
  input  logic [2:0] irq_en,
  input  logic       clr_wr,
  input  logic [1:0] clr_mask,
  output logic [1:0] status
);

  logic set_rx, set_tx;
  logic [1:0] clr_bits;

  assign set_rx   = rx_accept & irq_en[0];
  assign set_tx   = tx_retire & irq_en[1] & (~irq_en[2] | tx_drained);
  assign clr_bits = clr_wr ? clr_mask : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) status <= 2'b00;
    else        status <= (status & ~clr_bits) | {set_tx, set_rx};
  end

  assert_rx_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_accept && irq_en[0]) |=> status[0]);

  assert_tx_irq_only_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_retire && irq_en[2] && !tx_drained && !status[1]) |=> !status[1]);

endmodule

// File: rtl/mbx_fifo_pair.sv
module mbx_fifo_pair
  import mbxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [3:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        rx_valid,
  input  logic [31:0] rx_id,
  input  logic [3:0]  rx_dlc,
  input  logic [63:0] rx_data,
  output logic        rx_overrun,
  output logic        tx_valid,
  output logic [31:0] tx_id,
  output logic [3:0]  tx_dlc,
  output logic [63:0] tx_data,
  input  logic        tx_done,
  output logic        irq_rx,
  output logic        irq_tx
);

  logic          rx_en, tx_en;
  logic [2:0]    irq_en;
  frame_t        stage;
  frame_t        rx_head, tx_head, rx_in;
  logic [CW-1:0] rx_count, tx_count;
  logic          rx_full, rx_empty, tx_full, tx_empty;
  logic [1:0]    irq_status;

  // named internal events
  logic rx_accept, rx_pop, tx_commit, tx_retire, tx_drained, st_clear;

  function automatic logic wr_hit(input logic wr, input logic [3:0] a, input logic [3:0] b);
    return wr && (a == b);
  endfunction

  assign rx_in      = '{id: rx_id, dlc: rx_dlc, data: rx_data};
  assign rx_accept  = rx_valid && rx_en && !rx_full;
  assign rx_overrun = rx_valid && rx_en && rx_full;
  assign rx_pop     = wr_hit(host_wr, host_addr, A_RX_PTR) && is_key(host_wdata)
                      && rx_en && !rx_empty;
  assign tx_commit  = wr_hit(host_wr, host_addr, A_TX_PTR) && is_key(host_wdata)
                      && tx_en && !tx_full;
  assign tx_valid   = tx_en && !tx_empty;
  assign tx_retire  = tx_valid && tx_done;
  assign tx_drained = tx_retire && (tx_count == CW'(1)) && !tx_commit;
  assign st_clear   = wr_hit(host_wr, host_addr, A_IRQ_ST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en  <= 1'b0;
      tx_en  <= 1'b0;
      irq_en <= 3'b000;
      stage  <= '0;
    end else if (host_wr) begin
      case (host_addr)
        A_RX_CTL: rx_en        <= host_wdata[0];
        A_TX_CTL: tx_en        <= host_wdata[0];
        A_IRQ_EN: irq_en       <= host_wdata[2:0];
        A_TX_ID:  stage.id     <= host_wdata;
        A_TX_DLC: stage.dlc    <= host_wdata[3:0];
        A_TX_DLO: stage.data[31:0]  <= host_wdata;
        A_TX_DHI: stage.data[63:32] <= host_wdata;
        default: ;
      endcase
    end
  end

  msgq_ring #(.DEPTH(DEPTH)) u_rx_ring (
    .clk(clk), .rst_n(rst_n), .push(rx_accept), .push_frame(rx_in), .pop(rx_pop),
    .head(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  msgq_ring #(.DEPTH(DEPTH)) u_tx_ring (
    .clk(clk), .rst_n(rst_n), .push(tx_commit), .push_frame(stage), .pop(tx_retire),
    .head(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  msgq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .rx_accept(rx_accept), .tx_retire(tx_retire),
    .tx_drained(tx_drained), .irq_en(irq_en), .clr_wr(st_clear),
    .clr_mask(host_wdata[1:0]), .status(irq_status)
  );

  assign tx_id   = tx_head.id;
  assign tx_dlc  = tx_head.dlc;
  assign tx_data = tx_head.data;
  assign irq_rx  = irq_status[0];
  assign irq_tx  = irq_status[1];

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_RX_ID:  host_rdata = rx_head.id;
      A_RX_DLC: host_rdata = {28'd0, rx_head.dlc};
      A_RX_DLO: host_rdata = rx_head.data[31:0];
      A_RX_DHI: host_rdata = rx_head.data[63:32];
      A_TX_ID:  host_rdata = stage.id;
      A_TX_DLC: host_rdata = {28'd0, stage.dlc};
      A_TX_DLO: host_rdata = stage.data[31:0];
      A_TX_DHI: host_rdata = stage.data[63:32];
      A_RX_CTL: host_rdata = {24'd0, ctrl_byte(rx_en, 3'(rx_count), rx_empty)};
      A_TX_CTL: host_rdata = {24'd0, ctrl_byte(tx_en, 3'(tx_count), 1'b0)};
      A_IRQ_EN: host_rdata = {29'd0, irq_en};
      A_IRQ_ST: host_rdata = {30'd0, irq_status};
      default:  host_rdata = '0;
    endcase
  end

  assert_overrun_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !rx_pop) |=> $stable(rx_count));

  assert_retire_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_retire && !tx_commit) |=> tx_count == CW'($past(tx_count) - 1'b1));

  assert_ignored_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_TX_PTR && !tx_en && !tx_done) |=> $stable(tx_count));

endmodule

// File: tb/tb_mbx_fifo_pair.sv
module tb_mbx_fifo_pair;
  localparam int CLK_PERIOD = 10;
  localparam int QD = 4;

  logic        clk = 0, rst_n = 0;
  logic        host_wr = 0;
  logic [3:0]  host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic        rx_valid = 0;
  logic [31:0] rx_id = 0;
  logic [3:0]  rx_dlc = 0;
  logic [63:0] rx_data = 0;
  logic        rx_overrun, tx_valid, irq_rx, irq_tx;
  logic [31:0] tx_id;
  logic [3:0]  tx_dlc;
  logic [63:0] tx_data;
  logic        tx_done = 0;

  mbx_fifo_pair dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, fails = 0;
  logic [99:0] rxq[$];
  logic [99:0] txq[$];
  logic        m_rx_en = 0, m_tx_en = 0, m_rx_st = 0, m_tx_st = 0;
  logic [2:0]  m_ie = 0;
  logic [31:0] s_id = 0, s_lo = 0, s_hi = 0;
  logic [3:0]  s_dlc = 0;

  function automatic logic [99:0] mk(input logic [31:0] id, input logic [3:0] d,
                                     input logic [63:0] p);
    return {id, d, p};
  endfunction

  function automatic logic [31:0] exp_ctrl(input logic en, input int n, input logic rxside);
    logic [31:0] v = 0;
    v[0]   = en;
    v[3:1] = n[2:0];
    v[7]   = rxside && (n == 0);
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic hwrite(input logic [3:0] a, input logic [31:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
    cyc();
    host_wr = 0;
    case (a)
      4'd8:  m_rx_en = d[0];
      4'd9:  m_tx_en = d[0];
      4'd12: m_ie = d[2:0];
      4'd13: begin if (d[0]) m_rx_st = 0; if (d[1]) m_tx_st = 0; end
      4'd4:  s_id = d;
      4'd5:  s_dlc = d[3:0];
      4'd6:  s_lo = d;
      4'd7:  s_hi = d;
      4'd10: if (d[7:0] == 8'hFF && m_rx_en && rxq.size() > 0) void'(rxq.pop_front());
      4'd11: if (d[7:0] == 8'hFF && m_tx_en && txq.size() < QD)
               txq.push_back(mk(s_id, s_dlc, {s_hi, s_lo}));
      default: ;
    endcase
  endtask

  task automatic hread(input logic [3:0] a, output logic [31:0] v);
    host_addr = a; #1; v = host_rdata;
  endtask

  task automatic push_rx(input logic [31:0] id, input logic [3:0] d, input logic [63:0] p);
    logic ov_exp;
    rx_valid = 1; rx_id = id; rx_dlc = d; rx_data = p;
    ov_exp = m_rx_en && rxq.size() == QD;
    #1 chk("R5 overrun pulse", 64'(rx_overrun), 64'(ov_exp));
    cyc();
    rx_valid = 0;
    if (m_rx_en && rxq.size() < QD) begin
      rxq.push_back(mk(id, d, p));
      if (m_ie[0]) m_rx_st = 1;
    end
  endtask

  task automatic done_tx();
    logic drained;
    tx_done = 1;
    cyc();
    tx_done = 0;
    if (m_tx_en && txq.size() > 0) begin
      drained = txq.size() == 1;
      void'(txq.pop_front());
      if (m_ie[1] && (!m_ie[2] || drained)) m_tx_st = 1;
    end
  endtask

  task automatic stage_commit(input logic [7:0] key);
    hwrite(4'd4, $urandom);
    hwrite(4'd5, $urandom);
    hwrite(4'd6, $urandom);
    hwrite(4'd7, $urandom);
    hwrite(4'd11, {24'd0, key});
  endtask

  task automatic check_all();
    logic [31:0] v;
    hread(4'd8, v); chk("R2 rx control", 64'(v), 64'(exp_ctrl(m_rx_en, rxq.size(), 1)));
    hread(4'd9, v); chk("R2 tx control", 64'(v), 64'(exp_ctrl(m_tx_en, txq.size(), 0)));
    if (rxq.size() > 0) begin
      hread(4'd0, v); chk("R3 window id", 64'(v), 64'(rxq[0][99:68]));
      hread(4'd1, v); chk("R3 window dlc", 64'(v), 64'(rxq[0][67:64]));
      hread(4'd2, v); chk("R3 window lo", 64'(v), 64'(rxq[0][31:0]));
      hread(4'd3, v); chk("R3 window hi", 64'(v), 64'(rxq[0][63:32]));
    end
    chk("R9 irq_rx", 64'(irq_rx), 64'(m_rx_st));
    chk("R8 irq_tx", 64'(irq_tx), 64'(m_tx_st));
    chk("R7 tx_valid", 64'(tx_valid), 64'(m_tx_en && txq.size() > 0));
    if (m_tx_en && txq.size() > 0)
      chk("R7 tx head", {tx_id, 28'd0, tx_dlc}, {txq[0][99:68], 28'd0, txq[0][67:64]});
    if (m_tx_en && txq.size() > 0)
      chk("R7 tx payload", tx_data, txq[0][63:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R1 reset state
    hread(4'd8, v); chk("R1 rx ctrl reset", 64'(v), 64'h80);
    hread(4'd9, v); chk("R1 tx ctrl reset", 64'(v), 64'h00);
    chk("R1 tx_valid reset", 64'(tx_valid), 0);
    chk("R1 irq reset", {62'd0, irq_tx, irq_rx}, 0);

    // R3 disabled receive drops, R4 pointer ignored while disabled
    push_rx(32'h1111, 4'd1, 64'h1); check_all();
    hwrite(4'd8, 32'hFFFF_FF01);   // R2 only bit 0 writable
    hwrite(4'd9, 32'h1);
    hwrite(4'd12, 32'h1);
    check_all();
    for (int i = 0; i < 5; i++) begin
      push_rx(32'h8000_0000 | i, 4'(i + 3), {32'(i), 32'hA5A5_0000 + i});
      check_all();                 // 5th shows R5 drop with window unchanged
    end
    hwrite(4'd10, 32'h7E); check_all();   // R4 non-key ignored
    for (int i = 0; i < 5; i++) begin
      hwrite(4'd10, 32'hFF); check_all(); // last one: R4 empty ignored
    end
    hwrite(4'd13, 32'h1); check_all();    // R9 clear

    // R8 empty-only transmit interrupt
    hwrite(4'd12, 32'h6);
    stage_commit(8'hFF); stage_commit(8'hFF); check_all();
    done_tx(); check_all();
    done_tx(); check_all();
    hwrite(4'd13, 32'h2); check_all();
    hwrite(4'd12, 32'h2);
    stage_commit(8'hFF); stage_commit(8'hFF);
    done_tx(); check_all();               // R8 every completion
    done_tx(); hwrite(4'd13, 32'h3); check_all();
    // R6 full and non-key commits ignored
    for (int i = 0; i < 5; i++) begin stage_commit(8'hFF); check_all(); end
    stage_commit(8'h0F); check_all();
    hwrite(4'd9, 32'h0); stage_commit(8'hFF); done_tx(); check_all();
    hwrite(4'd9, 32'h1); check_all();

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r <= 2)      push_rx($urandom, 4'($urandom), {$urandom, $urandom});
      else if (r <= 4) hwrite(4'd10, ($urandom_range(0, 4) == 0) ? 32'h3C : 32'hFF);
      else if (r <= 6) stage_commit(($urandom_range(0, 4) == 0) ? 8'hF7 : 8'hFF);
      else if (r <= 8) done_tx();
      else begin
        case ($urandom_range(0, 3))
          0: hwrite(4'd8, 32'($urandom_range(0, 3) != 0));
          1: hwrite(4'd9, 32'($urandom_range(0, 3) != 0));
          2: hwrite(4'd12, $urandom);
          default: hwrite(4'd13, $urandom);
        endcase
      end
      check_all();
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule